// File: doc/BRIEF.md
# Pipelined Burst SRAM Access Controller

This block is the synchronous control front end of a pipelined, common-I/O burst SRAM. Every control input is captured on the rising clock edge. A burst starts when one of two address strobes is sampled low: the processor-side strobe or the controller-side strobe. The block then keeps a two-bit wraparound burst position and steps it while the advance input is low. The position runs in linear or interleaved order, chosen by a static mode input. Writes go into a small behavioural memory with per-byte masking. Reads leave through a registered data path. The data bus is modelled as separate `din` and `dout` ports with a drive flag `dout_en`.

The output drive logic follows the timing of a double-cycle-deselect pipelined SRAM. Outputs stay driven for one more cycle after a deselect is sampled. They are held off during the first cycle of an access that starts from the deselected state, and in any cycle where a write is taken. A sleep request takes effect two clocks after it is sampled and ends two clocks after it drops. Memory contents survive sleep.

Top module: `pbs_sram_ctl`

## Requirements
- R1: A low `cpu_strb_n` or `ctl_strb_n` at a rising edge loads the external address, and `addr[1:0]` becomes the burst start. When both strobes are low, only the processor strobe acts, so the cycle is a read even if write controls are active.
- R2: `cpu_strb_n` has no effect while `sel1_n` is sampled high. The chip selects (`sel1_n` low, `sel2` high, `sel3_n` low) are looked at only on edges that load a new address. An access in progress goes on reading when they drop on a later edge.
- R3: With `order_ilv` low, `step_n` low on a continuation edge moves the burst to start+count+1 in the two low address bits, wrapping modulo 4. The upper address bits stay unchanged.
- R4: With `order_ilv` high, the two low address bits of burst step k equal the start value XOR k.
- R5: An access started by `cpu_strb_n` is a read on its first edge, and `all_wr_n`, `byte_wr_n`, `byte_sel_n` and `step_n` are ignored on that edge. A write to that address is taken on the following edge from the write controls sampled there.
- R6: A write started by `ctl_strb_n` (with `cpu_strb_n` high) lands in the same edge at exactly `addr`. `step_n` is ignored on that edge.
- R7: `all_wr_n` low writes all byte lanes whatever `byte_wr_n` and `byte_sel_n` hold. Otherwise, with `byte_wr_n` low, lane b (`din[8b+7:8b]`) is written only when `byte_sel_n[b]` is low. Unselected lanes keep their contents. `byte_wr_n` low with no lane selected is a read.
- R8: The data of a read issued at one edge appears on `dout` after the next rising edge.
- R9: `dout_en` is low after reset. It is low during the first cycle of an access that starts from the deselected state. Otherwise it follows `out_en_n` low while read data is due.
- R10: After a deselect is sampled, `dout_en` stays high through the following cycle and drops after the next edge.
- R11: `dout_en` is forced low in the cycle after any edge that takes a write, regardless of `out_en_n`.
- R12: `sleep_req` high sampled at edge S leaves edges S and S+1 active, and edge S+2 onward is ignored. After `sleep_req` low is sampled at edge U, edges U and U+1 are still ignored and U+2 acts. Memory contents are kept, and writes presented while asleep are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_strb_n | input | 1 | Processor address strobe, active low, has priority |
| ctl_strb_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| sel1_n | input | 1 | Chip select, active low; also gates the processor strobe |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| all_wr_n | input | 1 | Global write of all lanes, active low |
| byte_wr_n | input | 1 | Byte write qualifier, active low |
| byte_sel_n | input | NB | Per-lane write selects, active low |
| addr | input | AW | Word address |
| din | input | NB*LW | Write data |
| out_en_n | input | 1 | Output enable, active low, not registered |
| order_ilv | input | 1 | Static burst order: 0 linear, 1 interleaved |
| sleep_req | input | 1 | Sleep request, active high |
| dout | output | NB*LW | Registered read data |
| dout_en | output | 1 | High when the data bus would be driven |

## Verification
The main collision is a processor-strobe write. Its second edge takes the write in the same cycle that the read result of its first edge is due at the output, so the drive-off rule and the read pipeline meet. The bench provokes this directly by holding `out_en_n` low across a two-edge processor write. It expects `dout_en` low and a byte-level readback showing only the second-edge lanes changed. Random strobes, selects and write controls bring up the same overlap many more times, as well as deselect tails running into new accesses. Every cycle is compared against a bench model of the memory and the output pipeline.

// File: rtl/pbs_pkg.sv
`timescale 1ns/1ps
package pbs_pkg;
  localparam int LO_W = 2;
  typedef logic [LO_W-1:0] lo_t;

  // Low address bits for burst position cnt from start, in the chosen order.
  function automatic lo_t burst_lo(lo_t start, lo_t cnt, logic ilv);
    return ilv ? (start ^ cnt) : lo_t'(start + cnt);
  endfunction
endpackage

// File: rtl/pbs_burst_ctr.sv
`timescale 1ns/1ps
module pbs_burst_ctr
  import pbs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic step,
  input  logic ilv,
  input  lo_t  start_in,
  output lo_t  cur_lo,
  output lo_t  nxt_lo
);
  lo_t start_q, start_d;
  lo_t cnt_q, cnt_d;

  always_comb begin
    start_d = start_q;
    cnt_d   = cnt_q;
    if (load) begin
      start_d = start_in;
      cnt_d   = '0;
    end else if (step) begin
      cnt_d = lo_t'(cnt_q + 2'd1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      cnt_q   <= '0;
    end else if (load || step) begin
      start_q <= start_d;
      cnt_q   <= cnt_d;
    end
  end

  assign cur_lo = burst_lo(start_q, cnt_q, ilv);
  assign nxt_lo = burst_lo(start_q, lo_t'(cnt_q + 2'd1), ilv);

  // R3: a linear step moves the low bits forward by one, wrapping.
  assert_lin_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !ilv) |=> (ilv || cur_lo == lo_t'($past(cur_lo) + 2'd1)));
endmodule

// File: rtl/pbs_mem_array.sv
`timescale 1ns/1ps
module pbs_mem_array #(
  parameter int AW = 4,
  parameter int NB = 4,
  parameter int LW = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [NB-1:0]     lane_en,
  input  logic [AW-1:0]     addr,
  input  logic [NB*LW-1:0]  wdata,
  output logic [NB*LW-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [LW-1:0] lane_mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we && lane_en[g]) lane_mem[addr] <= wdata[g*LW +: LW];
    end
    assign rdata[g*LW +: LW] = lane_mem[addr];
  end
endmodule

// File: rtl/pbs_out_stage.sv
`timescale 1ns/1ps
module pbs_out_stage #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_issue,
  input  logic          wr_issue,
  input  logic          sleep_req,
  input  logic          out_en_n,
  input  logic [DW-1:0] rd_word,
  output logic          asleep,
  output logic [DW-1:0] dout,
  output logic          dout_en
);
  logic          rd_v_q;
  logic          drive_q, drive_d;
  logic [DW-1:0] rdata_q, dout_q;
  logic [1:0]    slp_q;

  // Drive only one cycle behind a read; a write or sleep cancels it.
  always_comb drive_d = rd_v_q && !wr_issue && !slp_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_v_q  <= 1'b0;
      drive_q <= 1'b0;
      slp_q   <= '0;
    end else begin
      rd_v_q  <= rd_issue;
      drive_q <= drive_d;
      slp_q   <= {slp_q[0], sleep_req};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (rd_issue) rdata_q <= rd_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dout_q <= '0;
    else if (rd_v_q) dout_q <= rdata_q;
  end

  assign asleep  = slp_q[1];
  assign dout    = dout_q;
  assign dout_en = drive_q && !out_en_n;

  // R10: once reads stop, the bus is released after one more edge.
  assert_desel_tail_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_v_q |=> !drive_q);
  // R11: a taken write leaves the bus undriven in the following cycle.
  assert_wr_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_issue |=> !dout_en);
endmodule

// File: rtl/pbs_sram_ctl.sv
`timescale 1ns/1ps
module pbs_sram_ctl
  import pbs_pkg::*;
#(
  parameter int AW = 4,
  parameter int NB = 4,
  parameter int LW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_strb_n,
  input  logic              ctl_strb_n,
  input  logic              step_n,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              sel3_n,
  input  logic              all_wr_n,
  input  logic              byte_wr_n,
  input  logic [NB-1:0]     byte_sel_n,
  input  logic [AW-1:0]     addr,
  input  logic [NB*LW-1:0]  din,
  input  logic              out_en_n,
  input  logic              order_ilv,
  input  logic              sleep_req,
  output logic [NB*LW-1:0]  dout,
  output logic              dout_en
);
  localparam int DW = NB * LW;
  localparam int HW = AW - LO_W;

  logic          asleep, awake;
  logic          chip_ok, p_go, c_go, load, sel_new, desel, cont;
  logic          wr_req, do_wr, do_rd, step;
  logic          active_q, active_d;
  logic [HW-1:0] base_q;
  lo_t           cur_lo, nxt_lo;
  logic [AW-1:0] eff_addr;
  logic [NB-1:0] lane_en;
  logic [DW-1:0] rd_word;

  // Cycle decode
  always_comb begin
    awake   = !asleep;
    chip_ok = !sel1_n && sel2 && !sel3_n;
    p_go    = awake && !cpu_strb_n && !sel1_n;
    c_go    = awake && !ctl_strb_n && !p_go;
    load    = p_go || c_go;
    sel_new = load && chip_ok;
    desel   = load && !chip_ok;
    cont    = awake && !load && active_q;
    lane_en = !all_wr_n ? {NB{1'b1}} : (!byte_wr_n ? ~byte_sel_n : {NB{1'b0}});
    wr_req  = |lane_en;
    do_wr   = (c_go && chip_ok && wr_req) || (cont && wr_req);
    do_rd   = (p_go && chip_ok) || (c_go && chip_ok && !wr_req) || (cont && !wr_req);
    step    = cont && !step_n;
    eff_addr = load ? addr : {base_q, (step ? nxt_lo : cur_lo)};
  end

  always_comb begin
    active_d = active_q;
    if (asleep || desel) active_d = 1'b0;
    else if (sel_new)    active_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= 1'b0;
    else        active_q <= active_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (sel_new) base_q <= addr[AW-1:LO_W];
  end

  pbs_burst_ctr u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sel_new),
    .step     (step),
    .ilv      (order_ilv),
    .start_in (addr[LO_W-1:0]),
    .cur_lo   (cur_lo),
    .nxt_lo   (nxt_lo)
  );

  pbs_mem_array #(.AW(AW), .NB(NB), .LW(LW)) u_mem (
    .clk     (clk),
    .we      (do_wr),
    .lane_en (lane_en),
    .addr    (eff_addr),
    .wdata   (din),
    .rdata   (rd_word)
  );

  pbs_out_stage #(.DW(DW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_issue  (do_rd),
    .wr_issue  (do_wr),
    .sleep_req (sleep_req),
    .out_en_n  (out_en_n),
    .rd_word   (rd_word),
    .asleep    (asleep),
    .dout      (dout),
    .dout_en   (dout_en)
  );

  // R1: a selected processor strobe makes addr[1:0] the burst start.
  assert_cap_lo_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (p_go && chip_ok) |=> (cur_lo == $past(addr[LO_W-1:0])));
  // R9: an access leaving the deselected state keeps the bus off for a cycle.
  assert_first_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_new && !active_q) |=> !dout_en);
  // R12: while asleep nothing stays selected and the bus is released.
  assert_sleep_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |=> (!dout_en && !active_q));
endmodule

// File: tb/sim_pbs_sram_ctl.sv
`timescale 1ns/1ps
module sim_pbs_sram_ctl;
  localparam int AW = 4, NB = 4, LW = 8, DW = 32, DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_n, ctl_n, stp_n, s1n, s2, s3n, gwn, bwen, oen, ilv, zz;
  logic [NB-1:0] bsn;
  logic [AW-1:0] addr;
  logic [DW-1:0] din, dout;
  logic dout_en;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // bench model state
  logic [DW-1:0] ref_mem [DEPTH];
  logic m_act = 0, m_rdv = 0, m_drv = 0, m_s1 = 0, m_s2 = 0;
  logic [1:0] m_base = 0, m_start = 0, m_cnt = 0;
  logic [DW-1:0] m_rdat = 0, m_dout = 0;

  always #2.5 clk = ~clk;

  pbs_sram_ctl #(.AW(AW), .NB(NB), .LW(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_strb_n(cpu_n), .ctl_strb_n(ctl_n),
    .step_n(stp_n), .sel1_n(s1n), .sel2(s2), .sel3_n(s3n), .all_wr_n(gwn),
    .byte_wr_n(bwen), .byte_sel_n(bsn), .addr(addr), .din(din),
    .out_en_n(oen), .order_ilv(ilv), .sleep_req(zz), .dout(dout), .dout_en(dout_en)
  );

  function automatic logic [1:0] blo(logic [1:0] st, logic [1:0] k, logic il);
    return il ? (st ^ k) : 2'(st + k);
  endfunction

  function automatic logic [DW-1:0] fillv(int i);
    return {8'(i + 16), 8'(i + 32), 8'(i + 48), 8'(i + 64)};
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  // Reference behaviour for one rising edge, from the requirements.
  task automatic model_edge();
    logic awk, chip, pg, cg, ld, cn, st, wr, rd, wany;
    logic [NB-1:0] ln;
    logic [AW-1:0] ea;
    awk  = !m_s2;
    chip = !s1n && s2 && !s3n;
    pg   = awk && !cpu_n && !s1n;
    cg   = awk && !ctl_n && !pg;
    ld   = pg || cg;
    ln   = !gwn ? '1 : (!bwen ? ~bsn : '0);
    wany = |ln;
    cn   = awk && !ld && m_act;
    st   = cn && !stp_n;
    wr   = (cg && chip && wany) || (cn && wany);
    rd   = (pg && chip) || (cg && chip && !wany) || (cn && !wany);
    ea   = ld ? addr : {m_base, blo(m_start, st ? 2'(m_cnt + 2'd1) : m_cnt, ilv)};
    m_drv = m_rdv && !wr && awk;
    if (m_rdv) m_dout = m_rdat;
    m_rdv = rd;
    if (rd) m_rdat = ref_mem[ea];
    if (wr) for (int b = 0; b < NB; b++)
      if (ln[b]) ref_mem[ea][b*LW +: LW] = din[b*LW +: LW];
    if (ld && chip) begin
      m_act = 1; m_base = addr[AW-1:2]; m_start = addr[1:0]; m_cnt = 0;
    end else if (ld || !awk) m_act = 0;
    else if (st) m_cnt = 2'(m_cnt + 2'd1);
    m_s2 = m_s1;
    m_s1 = zz;
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    #1;
    chk("R9 dout_en vs model", 32'(dout_en), 32'(m_drv && !oen));
    if (m_drv && !oen) chk("R8 dout vs model", dout, m_dout);
  endtask

  task automatic idle_in();
    cpu_n = 1; ctl_n = 1; stp_n = 1; gwn = 1; bwen = 1; bsn = '1;
    s1n = 0; s2 = 1; s3n = 0;
  endtask

  task automatic deselect();
    idle_in(); ctl_n = 0; s2 = 0; tick(); idle_in();
  endtask

  task automatic wr_c(logic [AW-1:0] a, logic [DW-1:0] d);
    idle_in(); ctl_n = 0; gwn = 0; addr = a; din = d; tick(); idle_in();
  endtask

  task automatic rd_chk(logic [AW-1:0] a, logic [DW-1:0] exp, string tag);
    deselect();
    oen = 0; cpu_n = 0; addr = a; tick(); idle_in();
    chk("R9 first cycle off", 32'(dout_en), 32'd0);
    tick();
    chk(tag, dout, exp);
    chk("R8 driven after one edge", 32'(dout_en), 32'd1);
  endtask

  initial begin
    #(5 * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [DW-1:0] keep3, keep8;
    void'($urandom(32'd4711));
    idle_in(); oen = 0; ilv = 0; zz = 0; addr = '0; din = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset off", 32'(dout_en), 32'd0);
    rst_n = 1;

    for (int i = 0; i < DEPTH; i++) wr_c(AW'(i), fillv(i));

    // R6: controller-strobe write lands at addr in one edge, advance ignored
    idle_in(); ctl_n = 0; gwn = 0; stp_n = 0; addr = 9; din = 32'hC0FFEE09; tick(); idle_in();
    rd_chk(9, 32'hC0FFEE09, "R6 single-edge write");
    rd_chk(10, fillv(10), "R6 advance ignored");

    // R7: lane masking and global override
    idle_in(); ctl_n = 0; bwen = 0; bsn = 4'b1010; addr = 3; din = 32'h11223344; tick(); idle_in();
    rd_chk(3, {fillv(3)[31:24], 8'h22, fillv(3)[15:8], 8'h44}, "R7 byte lanes");
    idle_in(); ctl_n = 0; gwn = 0; bwen = 1; bsn = '1; addr = 7; din = 32'hA5A5A5A5; tick(); idle_in();
    rd_chk(7, 32'hA5A5A5A5, "R7 global overrides");
    idle_in(); ctl_n = 0; bwen = 0; bsn = '1; addr = 7; din = 32'h0; tick(); idle_in();
    rd_chk(7, 32'hA5A5A5A5, "R7 no lane selected");

    // R5 and R11: processor-strobe write takes two edges
    deselect();
    oen = 0; cpu_n = 0; gwn = 0; addr = 5; din = 32'hDEAD0000; tick(); idle_in();
    bwen = 0; bsn = 4'b1110; din = 32'h000000EE; tick(); idle_in();
    chk("R11 write forces off", 32'(dout_en), 32'd0);
    rd_chk(5, {fillv(5)[31:8], 8'hEE}, "R5 write on second edge");

    // R1: both strobes low, processor strobe wins, so no write
    deselect();
    cpu_n = 0; ctl_n = 0; gwn = 0; addr = 12; din = 32'hFFFFFFFF; tick(); idle_in();
    tick();
    chk("R1 priority read data", dout, fillv(12));
    rd_chk(12, fillv(12), "R1 no write under priority");

    // R2: gated processor strobe and selects ignored on continuation
    cpu_n = 0; s1n = 1; addr = 0; tick(); idle_in();
    s2 = 0; tick(); idle_in();
    chk("R2 ignored strobe keeps burst", dout, fillv(12));
    chk("R2 still driven", 32'(dout_en), 32'd1);
    tick();
    chk("R2 selects not looked at", dout, fillv(12));

    // R3: linear burst from 5 -> 5,6,7,4
    ilv = 0; deselect();
    cpu_n = 0; addr = 5; tick(); idle_in();
    stp_n = 0; tick(); chk("R8 first burst word", dout, ref_mem[5]);
    tick(); chk("R3 linear second", dout, ref_mem[6]);
    tick(); chk("R3 linear third", dout, ref_mem[7]);
    stp_n = 1; tick(); chk("R3 linear wrap", dout, ref_mem[4]);

    // R4: interleaved burst from 5 -> 5,4,7,6,5
    deselect(); ilv = 1;
    cpu_n = 0; addr = 5; tick(); idle_in();
    stp_n = 0; tick(); chk("R4 ilv first", dout, ref_mem[5]);
    tick(); chk("R4 ilv second", dout, ref_mem[4]);
    tick(); chk("R4 ilv third", dout, ref_mem[7]);
    tick(); chk("R4 ilv fourth", dout, ref_mem[6]);
    stp_n = 1; tick(); chk("R4 ilv wrap", dout, ref_mem[5]);

    // R9: output enable gating while reading
    oen = 1; #1; chk("R9 oe high off", 32'(dout_en), 32'd0);
    oen = 0; #1; chk("R9 oe low on", 32'(dout_en), 32'd1);

    // R10: double-cycle deselect
    ctl_n = 0; s2 = 0; tick(); idle_in();
    chk("R10 tail cycle driven", 32'(dout_en), 32'd1);
    tick();
    chk("R10 released", 32'(dout_en), 32'd0);

    // R12: sleep entry and exit timing, contents kept
    ilv = 0; keep3 = ref_mem[3]; keep8 = ref_mem[8];
    zz = 1;
    wr_c(1, 32'h51515151);
    wr_c(2, 32'h52525252);
    wr_c(3, 32'h53535353);
    tick(); tick();
    chk("R12 asleep bus off", 32'(dout_en), 32'd0);
    zz = 0;
    wr_c(4, 32'h54545454);
    wr_c(8, 32'h58585858);
    wr_c(11, 32'h5B5B5B5B);
    rd_chk(1, 32'h51515151, "R12 edge S active");
    rd_chk(2, 32'h52525252, "R12 edge S+1 active");
    rd_chk(3, keep3, "R12 edge S+2 ignored");
    rd_chk(4, fillv(4), "R12 edge U ignored");
    rd_chk(8, keep8, "R12 edge U+1 ignored");
    rd_chk(11, 32'h5B5B5B5B, "R12 edge U+2 active");

    // random mix, checked every cycle against the model
    for (int n = 0; n < 4000; n++) begin
      if (n % 1000 == 0) ilv = 1'(n / 1000);
      cpu_n = ($urandom % 4 != 0);
      ctl_n = ($urandom % 3 != 0);
      stp_n = ($urandom % 2 != 0);
      s1n   = ($urandom % 8 == 0);
      s2    = ($urandom % 10 != 0);
      s3n   = ($urandom % 12 == 0);
      gwn   = ($urandom % 4 != 0);
      bwen  = ($urandom % 2 != 0);
      bsn   = 4'($urandom);
      oen   = ($urandom % 5 == 0);
      zz    = ($urandom % 60 == 0) ? ~zz : zz;
      addr  = AW'($urandom);
      din   = $urandom;
      tick();
    end
    zz = 0; idle_in();
    repeat (4) tick();
    for (int i = 0; i < DEPTH; i++) rd_chk(AW'(i), ref_mem[i], "R7 final contents");
    summary();
  end
endmodule